// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This core runs a tiny accumulator instruction set. Each instruction takes three cycles: fetch, decode and execute. A 16-bit instruction word carries an opcode in bits [15:8] and an 8-bit operand in bits [7:0]. The operand is either a memory address or an immediate. The core holds a program counter, a memory address register, an instruction register, an accumulator and an 8-bit output register.

The core drives one external single-port synchronous memory. The memory has a one-cycle read latency, and its registered read data serves as the core's memory data register. The address the core drives in a cycle is the address register's next value, so the read data appear one cycle later.
- A fetch uses the address register, which already holds the program counter.
- The decode cycle drives the operand address. The operand then arrives in the execute cycle.
- The execute cycle drives the next program counter, which prepares the following fetch.

The memory interface is a plain address/strobe bus with no back-pressure: the memory must return data every cycle with exactly one cycle of latency. Debug outputs show the program counter, instruction register, memory data and accumulator.

Top module: `acc_cpu_core`

## Requirements
- R1: Bits [15:8] of an instruction are the opcode and bits [7:0] are the operand. The opcodes are: 00 ADD, 01 STORE, 02 LOAD, 03 JUMP, 04 JNEG, 05 SUB, 06 XOR, 07 OR, 08 AND, 09 JPOS, 0A JZERO, 0B ADDI, 0C OUT, 0D SHL, 0E SHR.
- R2: A synchronous active-high reset clears the program counter, accumulator, instruction register and output register, and holds `mem_we` low. In the first cycle after reset is released, `mem_addr` is 0x00. In the next cycle the word at 0x00 is on the read data, and that cycle is the first fetch.
- R3: Every instruction takes exactly three cycles. At the end of the fetch cycle, the instruction register takes the memory read data and the program counter increments by one, wrapping at 8 bits.
- R4: In the decode cycle, `mem_addr` equals the operand field. In the execute cycle, the read data equal the memory word at that address.
- R5: For STORE, `mem_we` is high only in the decode cycle, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator. The accumulator does not change. The sequence LOAD 0x81, ADD 0x82, STORE 0x80 leaves mem[0x80] equal to mem[0x81] + mem[0x82].
- R6: LOAD, ADD, SUB, XOR, OR and AND combine the accumulator with the memory word at the operand address. ADD and SUB wrap modulo 2^16, and the logic operations act bit by bit.
- R7: ADDI adds the zero-extended 8-bit operand to the accumulator. SHL and SHR shift the accumulator by operand bits [3:0] only. SHR is a logical shift that fills with zeros.
- R8: JUMP loads the program counter with the operand. The next fetch reads from that address.
- R9: The accumulator is read as a two's-complement number for the conditional jumps. JNEG jumps when it is below zero, JPOS when it is above zero, and JZERO when it is zero. A jump that is not taken leaves the program counter at the next instruction.
- R10: OUT copies accumulator bits [7:0] into `out_data` and leaves the accumulator unchanged.
- R11: Opcodes 0x0F to 0xFF change no register except the program counter increment and cause no memory write.
- R12: In the execute cycle, `mem_addr` is the address of the next instruction, whether a jump was taken or not. `mem_we` is low in every cycle other than a STORE decode.
- R13: `dbg_pc`, `dbg_ir` and `dbg_ac` show the program counter, instruction register and accumulator. `dbg_mdr` shows the memory read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address; the read data follow one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_rdata | input | 16 | Registered memory read data |
| out_data | output | 8 | Output register written by OUT |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_mdr | output | 16 | Memory data as seen by the core |
| dbg_ac | output | 16 | Accumulator |

## Verification
Two functions share the single memory port in the same cycle. In a STORE decode cycle, the write to the operand address coincides with a read of that same address. The bench checks that the write goes through and that the stale read data are ignored.

The program also has a STORE that overwrites an instruction a few words ahead, so a write and a later fetch of the same word interact. A LOAD right after a STORE reads the stored word back. A reference model at instruction level, with its own memory copy, judges both cases: the overwritten instruction must execute with its new encoding, and the reloaded value must match.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    ST_RESET,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC
  } phase_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_ALU,
    K_STORE,
    K_JUMP,
    K_OUT
  } kind_e;

  typedef enum logic [2:0] {
    A_ADD,
    A_SUB,
    A_XOR,
    A_OR,
    A_AND,
    A_PASS,
    A_SHL,
    A_SHR
  } alu_op_e;

  typedef enum logic [1:0] {
    C_ALWAYS,
    C_NEG,
    C_POS,
    C_ZERO
  } cond_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e alu;
    logic    imm;
    cond_e   cond;
  } dec_t;

  localparam dec_t DEC_NOP = '{kind: K_NOP, alu: A_PASS, imm: 1'b0, cond: C_ALWAYS};

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  // R1 opcode map; R11 everything else is a no-operation
  always_comb begin
    dec = DEC_NOP;
    case (opc)
      OPC_W'(8'h00): dec = '{kind: K_ALU,   alu: A_ADD,  imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h01): dec = '{kind: K_STORE, alu: A_PASS, imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h02): dec = '{kind: K_ALU,   alu: A_PASS, imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h03): dec = '{kind: K_JUMP,  alu: A_PASS, imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h04): dec = '{kind: K_JUMP,  alu: A_PASS, imm: 1'b0, cond: C_NEG};
      OPC_W'(8'h05): dec = '{kind: K_ALU,   alu: A_SUB,  imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h06): dec = '{kind: K_ALU,   alu: A_XOR,  imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h07): dec = '{kind: K_ALU,   alu: A_OR,   imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h08): dec = '{kind: K_ALU,   alu: A_AND,  imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h09): dec = '{kind: K_JUMP,  alu: A_PASS, imm: 1'b0, cond: C_POS};
      OPC_W'(8'h0A): dec = '{kind: K_JUMP,  alu: A_PASS, imm: 1'b0, cond: C_ZERO};
      OPC_W'(8'h0B): dec = '{kind: K_ALU,   alu: A_ADD,  imm: 1'b1, cond: C_ALWAYS};
      OPC_W'(8'h0C): dec = '{kind: K_OUT,   alu: A_PASS, imm: 1'b0, cond: C_ALWAYS};
      OPC_W'(8'h0D): dec = '{kind: K_ALU,   alu: A_SHL,  imm: 1'b1, cond: C_ALWAYS};
      OPC_W'(8'h0E): dec = '{kind: K_ALU,   alu: A_SHR,  imm: 1'b1, cond: C_ALWAYS};
      default:       dec = DEC_NOP;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  // R6 memory-operand ops, R7 immediate add and shifts by low bits only
  always_comb begin
    case (op)
      A_ADD:   y = a + b;
      A_SUB:   y = a - b;
      A_XOR:   y = a ^ b;
      A_OR:    y = a | b;
      A_AND:   y = a & b;
      A_PASS:  y = b;
      A_SHL:   y = a << sh;
      A_SHR:   y = a >> sh;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/acc_cond.sv
module acc_cond
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cond_e             cond,
  input  logic [DATA_W-1:0] ac,
  output logic              taken
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = ac[DATA_W-1];
  assign is_zero = (ac == '0);

  // R9 signed branch tests
  always_comb begin
    case (cond)
      C_ALWAYS: taken = 1'b1;
      C_NEG:    taken = is_neg;
      C_POS:    taken = !is_neg && !is_zero;
      C_ZERO:   taken = is_zero;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  dec_t   dec_in,
  output phase_e phase,
  output dec_t   dec_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_RESET;
      dec_q <= DEC_NOP;
    end else begin
      case (phase)
        ST_RESET:  phase <= ST_FETCH;
        ST_FETCH:  phase <= ST_DECODE;
        ST_DECODE: begin
          dec_q <= dec_in;
          phase <= ST_EXEC;
        end
        ST_EXEC:   phase <= ST_FETCH;
        default:   phase <= ST_RESET;
      endcase
    end
  end

  // R2
  reset_leave_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phase == ST_RESET);

  // R3
  three_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC) |=> (phase == ST_FETCH));

  // R3
  decode_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FETCH) |=> (phase == ST_DECODE));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OUT_W-1:0]  out_data,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_ac
);

  localparam int OPC_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [ADDR_W-1:0] mar_next;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] ac;
  logic [OUT_W-1:0]  out_q;

  logic [ADDR_W-1:0] field;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;
  logic              taken;
  phase_e            phase;
  dec_t              dec;
  dec_t              dec_q;

  assign field   = ir[ADDR_W-1:0];
  assign imm_ext = {{OPC_W{1'b0}}, field};
  assign alu_b   = dec_q.imm ? imm_ext : mem_rdata;

  acc_decoder #(.OPC_W(OPC_W)) u_dec (
    .opc (ir[DATA_W-1 -: OPC_W]),
    .dec (dec)
  );

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dec_in (dec),
    .phase  (phase),
    .dec_q  (dec_q)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op (dec_q.alu),
    .a  (ac),
    .b  (alu_b),
    .y  (alu_y)
  );

  acc_cond #(.DATA_W(DATA_W)) u_cond (
    .cond  (dec_q.cond),
    .ac    (ac),
    .taken (taken)
  );

  // Address steering: the memory registers this address, so data follow a cycle later
  always_comb begin
    mar_next = mar;
    case (phase)
      ST_RESET:  mar_next = '0;
      ST_FETCH:  mar_next = mar;
      ST_DECODE: mar_next = field;
      ST_EXEC:   mar_next = (dec_q.kind == K_JUMP && taken) ? field : pc;
      default:   mar_next = mar;
    endcase
    if (rst) mar_next = '0;
  end

  assign mem_addr  = mar_next;
  assign mem_we    = !rst && (phase == ST_DECODE) && (dec.kind == K_STORE);
  assign mem_wdata = ac;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      mar   <= '0;
      ir    <= '0;
      ac    <= '0;
      out_q <= '0;
    end else begin
      mar <= mar_next;
      case (phase)
        ST_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
        end
        ST_EXEC: begin
          case (dec_q.kind)
            K_ALU:   ac <= alu_y;
            K_OUT:   out_q <= ac[OUT_W-1:0];
            K_JUMP:  if (taken) pc <= field;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign out_data = out_q;
  assign dbg_pc   = pc;
  assign dbg_ir   = ir;
  assign dbg_mdr  = mem_rdata;
  assign dbg_ac   = ac;

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FETCH) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R5
  store_bus_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase == ST_DECODE && mem_addr == field && mem_wdata == ac));

  // R10
  out_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && dec_q.kind == K_OUT) |=>
      (ac == $past(ac) && out_data == $past(ac[OUT_W-1:0])));

  // R12
  exec_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC) |=> (mar == pc));

  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && dec_q.kind == K_NOP) |=>
      (ac == $past(ac) && pc == $past(pc)));

endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [7:0]  out_data;
  logic [7:0]  dbg_pc;
  logic [15:0] dbg_ir;
  logic [15:0] dbg_mdr;
  logic [15:0] dbg_ac;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_cpu_core u0 (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_data(out_data), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_mdr(dbg_mdr), .dbg_ac(dbg_ac)
  );

  // Bench memory: one-cycle registered read, write on strobe
  logic [15:0] ram [256];
  logic [15:0] ram_q = '0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    ram_q <= ram[mem_addr];
  end
  assign mem_rdata = ram_q;

  // Behavioural reference
  logic [15:0] mm [256];
  logic [7:0]  m_pc;
  logic [15:0] m_ac;
  logic [7:0]  m_out;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] w);
    ram[a] = w;
    mm[a]  = w;
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) put(i, 16'h0000);
    put(8'h00, 16'h0281); put(8'h01, 16'h0082); put(8'h02, 16'h0180); put(8'h03, 16'h0280);
    put(8'h04, 16'h0583); put(8'h05, 16'h0C00); put(8'h06, 16'h0408); put(8'h07, 16'h0000);
    put(8'h08, 16'h0909); put(8'h09, 16'h0A30); put(8'h0A, 16'h0684); put(8'h0B, 16'h0910);
    put(8'h0C, 16'h0A0E); put(8'h0D, 16'h0B99); put(8'h0E, 16'h0B05); put(8'h0F, 16'h0911);
    put(8'h10, 16'h0B40); put(8'h11, 16'h0D13); put(8'h12, 16'h0E02); put(8'h13, 16'h0785);
    put(8'h14, 16'h0E0F); put(8'h15, 16'h0886); put(8'h16, 16'h0FAA); put(8'h17, 16'hFF00);
    put(8'h18, 16'h0C00); put(8'h19, 16'h031B); put(8'h1A, 16'h0B77); put(8'h1B, 16'h011D);
    put(8'h1C, 16'h0419); put(8'h1D, 16'h0C00); put(8'h1E, 16'h0BFF); put(8'h1F, 16'h031F);
    put(8'h81, 16'h1234); put(8'h82, 16'h0101); put(8'h83, 16'h2000);
    put(8'h84, 16'hF335); put(8'h85, 16'h8000); put(8'h86, 16'h00FF);
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h01: return "R5";
      8'h00, 8'h02, 8'h05, 8'h06, 8'h07, 8'h08: return "R6";
      8'h0B, 8'h0D, 8'h0E: return "R7";
      8'h03: return "R8";
      8'h04, 8'h09, 8'h0A: return "R9";
      8'h0C: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step();
    logic [15:0] ins;
    logic [7:0]  op;
    logic [7:0]  f;
    logic [15:0] opnd;
    ins  = mm[m_pc];
    op   = ins[15:8];
    f    = ins[7:0];
    opnd = mm[f];
    m_pc = m_pc + 8'd1;
    case (op)
      8'h00: m_ac = m_ac + opnd;
      8'h01: mm[f] = m_ac;
      8'h02: m_ac = opnd;
      8'h03: m_pc = f;
      8'h04: if ($signed(m_ac) < 0) m_pc = f;
      8'h05: m_ac = m_ac - opnd;
      8'h06: m_ac = m_ac ^ opnd;
      8'h07: m_ac = m_ac | opnd;
      8'h08: m_ac = m_ac & opnd;
      8'h09: if ($signed(m_ac) > 0) m_pc = f;
      8'h0A: if (m_ac == 16'h0) m_pc = f;
      8'h0B: m_ac = m_ac + {8'h00, f};
      8'h0C: m_out = m_ac[7:0];
      8'h0D: m_ac = m_ac << f[3:0];
      8'h0E: m_ac = m_ac >> f[3:0];
      default: ;
    endcase
  endtask

  // Runs one instruction starting from a fetch-phase negedge, ends at the next one
  task automatic run_instr();
    logic [15:0] ins;
    string       rq;
    ins = mm[m_pc];
    rq  = req_of(ins[15:8]);
    @(negedge clk); // decode cycle
    chk("R3", "ir after fetch", dbg_ir, ins);
    chk("R3", "pc increment", {8'h00, dbg_pc}, {8'h00, m_pc + 8'd1});
    chk("R4", "decode address", {8'h00, mem_addr}, {8'h00, ins[7:0]});
    chk("R1", "ir opcode field", {8'h00, dbg_ir[15:8]}, {8'h00, ins[15:8]});
    if (ins[15:8] == 8'h01) begin
      chk("R5", "store strobe", {15'h0, mem_we}, 16'h1);
      chk("R5", "store data", mem_wdata, m_ac);
    end else begin
      chk("R12", "no write in decode", {15'h0, mem_we}, 16'h0);
    end
    @(negedge clk); // execute cycle
    chk("R12", "no write in execute", {15'h0, mem_we}, 16'h0);
    if (ins[15:8] != 8'h01)
      chk("R4", "operand read data", dbg_mdr, mm[ins[7:0]]);
    model_step();
    chk("R12", "next fetch address", {8'h00, mem_addr}, {8'h00, m_pc});
    @(negedge clk); // next fetch cycle
    chk(rq, "pc after execute", {8'h00, dbg_pc}, {8'h00, m_pc});
    chk(rq, "accumulator", dbg_ac, m_ac);
    chk(rq, "output register", {8'h00, out_data}, {8'h00, m_out});
    chk("R13", "fetched word", dbg_mdr, mm[m_pc]);
    chk("R12", "no write in fetch", {15'h0, mem_we}, 16'h0);
  endtask

  task automatic reset_and_check();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "pc in reset", {8'h00, dbg_pc}, 16'h0);
    chk("R2", "ac in reset", dbg_ac, 16'h0);
    chk("R2", "out in reset", {8'h00, out_data}, 16'h0);
    chk("R2", "no write in reset", {15'h0, mem_we}, 16'h0);
    rst = 1'b0;
    m_pc = 8'h00; m_ac = 16'h0; m_out = 8'h00;
    chk("R2", "first address", {8'h00, mem_addr}, 16'h0);
    @(negedge clk); // first fetch cycle
    chk("R2", "first word on bus", dbg_mdr, mm[8'h00]);
    chk("R2", "ir after reset", dbg_ir, 16'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    load_program();
    reset_and_check();
    for (int n = 0; n < 3; n++) run_instr();
    // R5: LOAD/ADD/STORE sequence result in memory
    chk("R5", "stored sum", ram[8'h80], ram[8'h81] + ram[8'h82]);
    for (int n = 0; n < 33; n++) run_instr();
    // R5 store over code: word 0x1D was rewritten
    chk("R5", "code overwrite", ram[8'h1D], 16'h0001);
    // Mid-run reset, then rerun against the modified memory
    reset_and_check();
    for (int n = 0; n < 14; n++) run_instr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule